// File: doc/BRIEF.md
# Translation Buffer Refill Register Port

This block is the register-side path that software uses to load entries into an address translation buffer. It has four word registers on a simple write port. A selection register names the target slot by way and index. A high-word register holds the virtual page and tag word, and a cause register always mirrors the last high-word write. A low-word register holds the physical page and flag word. Reads of any register return its value in the same cycle.

A write to the low-word register is the commit action. The low word comes from the write data, and the high word is taken from the cause register. Both words go into one of two banks: instruction or data. The external `bank_sel` value chooses the bank. A value of 1 targets bank 0 and a value of 2 targets bank 1. Any other value leaves the banks untouched.

In the cycle after a commit, the block raises a one-cycle invalidate request. The request carries the page address of the entry just written, so that a downstream cache can drop its stale copy. An entry read port exposes the stored words of any slot for the translation logic.

Top module: `tlbm_top`

## Requirements
- R1: After reset the selection, low-word, high-word and cause registers read zero, every stored entry in both banks reads zero, and `inval_valid` is low.
- R2: A write to register address 0 (selection) stores bits 5:0 of the data. Bits 3:0 are the entry index and bits 5:4 are the way. A read of address 0 returns those six bits with all upper bits zero.
- R3: A write to register address 2 (high word) loads the same value into both the high-word register and the cause register (read at address 3).
- R4: A write to register address 3 (cause) is ignored, and the cause register keeps its value.
- R5: A write to register address 1 (low word) while `bank_sel` is 1 stores the write data as the low word and the current cause value as the high word. The target is bank 0, at the way and index held in the selection register.
- R6: The same low-word write while `bank_sel` is 2 stores into bank 1 instead.
- R7: A low-word write while `bank_sel` is 0 or 3 changes no stored entry and raises no invalidate request. The low-word register still takes the written value.
- R8: Each commit raises `inval_valid` for exactly the one cycle that follows the commit edge. `inval_addr` then equals the committed high word with bits 12:0 cleared. Two commits on consecutive cycles give two consecutive pulses.
- R9: A commit changes only the addressed slot, and all other slots in both banks keep their contents.
- R10: `rd_data` follows `rd_addr` with no clock edge in between (0 = selection, 1 = low, 2 = high, 3 = cause).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| bank_sel | input | 2 | Bank gate: 1 = bank 0, 2 = bank 1, others = no commit |
| ent_bank | input | 1 | Entry read bank |
| ent_way | input | 2 | Entry read way |
| ent_idx | input | 4 | Entry read index |
| ent_lo | output | 32 | Stored low word of the addressed entry |
| ent_hi | output | 32 | Stored high word of the addressed entry |
| inval_valid | output | 1 | One-cycle page invalidate request |
| inval_addr | output | 32 | Page address of the invalidate request |

## Verification
Two functions can fall in the same cycle: the invalidate pulse of one commit, and a register write that feeds the next commit. The bench writes a new high word in the cycle where the previous pulse is live, and it also issues two low-word writes back to back. Each pulse must carry the page of its own commit and never the page of the newer high word. The back-to-back writes must give two adjacent pulses and leave the later words in the slot.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
   typedef enum logic [1:0] {
      TLBM_REG_SEL   = 2'd0,
      TLBM_REG_LO    = 2'd1,
      TLBM_REG_HI    = 2'd2,
      TLBM_REG_CAUSE = 2'd3
   } tlbm_reg_e;

   function automatic int unsigned tlbm_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tlbm_regs.sv
module tlbm_regs #(
   parameter int unsigned DW    = 32,
   parameter int unsigned SEL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [1:0]       rd_addr,
   output logic [DW-1:0]    rd_data,
   output logic [SEL_W-1:0] sel_q,
   output logic [DW-1:0]    cause_q,
   output logic             lo_wr
);
   import tlbm_pkg::*;

   logic [DW-1:0] lo_q, hi_q;

   assign lo_wr = wr_en && (wr_addr == TLBM_REG_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         cause_q <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            TLBM_REG_SEL: sel_q <= wr_data[SEL_W-1:0];
            TLBM_REG_LO:  lo_q  <= wr_data;
            TLBM_REG_HI: begin
               hi_q    <= wr_data;
               cause_q <= wr_data;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (rd_addr)
         TLBM_REG_SEL: rd_data = {{(DW-SEL_W){1'b0}}, sel_q};
         TLBM_REG_LO:  rd_data = lo_q;
         TLBM_REG_HI:  rd_data = hi_q;
         default:      rd_data = cause_q;
      endcase
   end
endmodule

// File: rtl/tlbm_store.sv
module tlbm_store #(
   parameter int unsigned DW    = 32,
   parameter int unsigned NBANK = 2,
   parameter int unsigned NWAY  = 4,
   parameter int unsigned NIDX  = 16,
   localparam int unsigned BANK_W = tlbm_pkg::tlbm_bits(NBANK),
   localparam int unsigned WAY_W  = tlbm_pkg::tlbm_bits(NWAY),
   localparam int unsigned IDX_W  = tlbm_pkg::tlbm_bits(NIDX),
   localparam int unsigned SLOTS  = NWAY * NIDX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] w_bank,
   input  logic [WAY_W-1:0]  w_way,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [DW-1:0]     w_lo,
   input  logic [DW-1:0]     w_hi,
   input  logic [BANK_W-1:0] r_bank,
   input  logic [WAY_W-1:0]  r_way,
   input  logic [IDX_W-1:0]  r_idx,
   output logic [DW-1:0]     r_lo,
   output logic [DW-1:0]     r_hi
);
   logic [DW-1:0] bank_lo [NBANK];
   logic [DW-1:0] bank_hi [NBANK];

   wire [WAY_W+IDX_W-1:0] w_slot = {w_way, w_idx};
   wire [WAY_W+IDX_W-1:0] r_slot = {r_way, r_idx};

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] lo_mem [SLOTS];
      logic [DW-1:0] hi_mem [SLOTS];
      wire bank_we = we && (w_bank == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
               lo_mem[s] <= '0;
               hi_mem[s] <= '0;
            end
         end else if (bank_we) begin
            lo_mem[w_slot] <= w_lo;
            hi_mem[w_slot] <= w_hi;
         end
      end

      assign bank_lo[b] = lo_mem[r_slot];
      assign bank_hi[b] = hi_mem[r_slot];
   end

   always_comb begin
      r_lo = '0;
      r_hi = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (r_bank == BANK_W'(b)) begin
            r_lo = bank_lo[b];
            r_hi = bank_hi[b];
         end
      end
   end
endmodule

// File: rtl/tlbm_inval.sv
module tlbm_inval #(
   parameter int unsigned DW         = 32,
   parameter int unsigned PAGE_SHIFT = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic [DW-1:0] commit_hi,
   output logic          inval_valid,
   output logic [DW-1:0] inval_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inval_valid <= 1'b0;
         inval_addr  <= '0;
      end else begin
         inval_valid <= commit;
         if (commit)
            inval_addr <= {commit_hi[DW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      end
   end
endmodule

// File: rtl/tlbm_top.sv
module tlbm_top #(
   parameter int unsigned DW         = 32,
   parameter int unsigned NBANK      = 2,
   parameter int unsigned NWAY       = 4,
   parameter int unsigned NIDX       = 16,
   parameter int unsigned PAGE_SHIFT = 13,
   localparam int unsigned BANK_W = tlbm_pkg::tlbm_bits(NBANK),
   localparam int unsigned BSEL_W = tlbm_pkg::tlbm_bits(NBANK + 2),
   localparam int unsigned WAY_W  = tlbm_pkg::tlbm_bits(NWAY),
   localparam int unsigned IDX_W  = tlbm_pkg::tlbm_bits(NIDX),
   localparam int unsigned SEL_W  = WAY_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic [BSEL_W-1:0] bank_sel,
   input  logic [BANK_W-1:0] ent_bank,
   input  logic [WAY_W-1:0]  ent_way,
   input  logic [IDX_W-1:0]  ent_idx,
   output logic [DW-1:0]     ent_lo,
   output logic [DW-1:0]     ent_hi,
   output logic              inval_valid,
   output logic [DW-1:0]     inval_addr
);
   if (PAGE_SHIFT == 0 || PAGE_SHIFT >= DW) begin : g_bad_shift
      $error("tlbm_top: PAGE_SHIFT must lie in 1..DW-1");
   end
   if (SEL_W > DW) begin : g_bad_sel
      $error("tlbm_top: selection field wider than data word");
   end

   logic [SEL_W-1:0] sel_q;
   logic [DW-1:0]    cause_q;
   logic             lo_wr;
   logic             bank_ok;
   logic             commit;
   logic [BANK_W-1:0] w_bank;

   tlbm_regs #(.DW(DW), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sel_q(sel_q), .cause_q(cause_q), .lo_wr(lo_wr)
   );

   assign bank_ok = (bank_sel != '0) && (int'(bank_sel) <= int'(NBANK));
   assign commit  = lo_wr && bank_ok;
   assign w_bank  = BANK_W'(bank_sel - BSEL_W'(1));

   tlbm_store #(.DW(DW), .NBANK(NBANK), .NWAY(NWAY), .NIDX(NIDX)) u_store (
      .clk(clk), .rst_n(rst_n), .we(commit), .w_bank(w_bank),
      .w_way(sel_q[SEL_W-1:IDX_W]), .w_idx(sel_q[IDX_W-1:0]),
      .w_lo(wr_data), .w_hi(cause_q),
      .r_bank(ent_bank), .r_way(ent_way), .r_idx(ent_idx),
      .r_lo(ent_lo), .r_hi(ent_hi)
   );

   tlbm_inval #(.DW(DW), .PAGE_SHIFT(PAGE_SHIFT)) u_inval (
      .clk(clk), .rst_n(rst_n), .commit(commit), .commit_hi(cause_q),
      .inval_valid(inval_valid), .inval_addr(inval_addr)
   );
endmodule

// File: rtl/tlbm_chk.sv
module tlbm_chk #(
   parameter int unsigned DW         = 32,
   parameter int unsigned SEL_W      = 6,
   parameter int unsigned BSEL_W     = 2,
   parameter int unsigned PAGE_SHIFT = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DW-1:0]     wr_data,
   input logic [1:0]        rd_addr,
   input logic [DW-1:0]     rd_data,
   input logic [BSEL_W-1:0] bank_sel,
   input logic              inval_valid,
   input logic [DW-1:0]     inval_addr,
   input logic [DW-1:0]     cause_q
);
   wire lo_commit = wr_en && (wr_addr == 2'd1) &&
                    (bank_sel == BSEL_W'(1) || bank_sel == BSEL_W'(2));

   assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_commit |=> inval_valid);

   assert_no_spurious_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inval_valid |-> $past(lo_commit));

   assert_page_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      inval_valid |-> (inval_addr[PAGE_SHIFT-1:0] == '0));

   assert_page_from_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inval_valid |-> (inval_addr[DW-1:PAGE_SHIFT] == $past(cause_q[DW-1:PAGE_SHIFT])));

   assert_hi_mirrors_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> (cause_q == $past(wr_data)));

   assert_cause_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> $stable(cause_q));

   assert_sel_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 2'd0) |-> (rd_data[DW-1:SEL_W] == '0));
endmodule

bind tlbm_top tlbm_chk #(
   .DW(DW), .SEL_W(SEL_W), .BSEL_W(BSEL_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
   .bank_sel(bank_sel), .inval_valid(inval_valid), .inval_addr(inval_addr),
   .cause_q(cause_q)
);

// File: tb/tlbm_top_tb.sv
module tlbm_top_tb;
   localparam logic [1:0] A_SEL = 2'd0, A_LO = 2'd1, A_HI = 2'd2, A_CAUSE = 2'd3;
   localparam logic [31:0] PMASK = 32'hFFFF_E000;

   // bank_sel[71:70] way[69:68] idx[67:64] hi[63:32] lo[31:0]
   localparam logic [71:0] VEC [0:5] = '{
      {2'd1, 2'd0, 4'd0,  32'hABCD_E0FF, 32'h1234_5678},
      {2'd2, 2'd3, 4'd15, 32'hFFFF_FFFF, 32'h0000_001F},
      {2'd1, 2'd2, 4'd7,  32'h0000_4000, 32'h8000_0001},
      {2'd2, 2'd1, 4'd9,  32'h1357_9BDF, 32'h2468_ACE0},
      {2'd1, 2'd3, 4'd0,  32'h0000_0000, 32'hFFFF_FFFF},
      {2'd2, 2'd0, 4'd15, 32'h8000_1FFF, 32'h0F0F_0F0F}
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  bank_sel = '0;
   logic        ent_bank = 1'b0;
   logic [1:0]  ent_way = '0;
   logic [3:0]  ent_idx = '0;
   logic [31:0] ent_lo, ent_hi;
   logic        inval_valid;
   logic [31:0] inval_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   tlbm_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .bank_sel(bank_sel), .ent_bank(ent_bank), .ent_way(ent_way),
      .ent_idx(ent_idx), .ent_lo(ent_lo), .ent_hi(ent_hi),
      .inval_valid(inval_valid), .inval_addr(inval_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdreg(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic rdent(input logic b, input logic [1:0] w, input logic [3:0] i,
                        output logic [31:0] lo, output logic [31:0] hi);
      ent_bank = b; ent_way = w; ent_idx = i;
      #1 lo = ent_lo; hi = ent_hi;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, lo, hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rdreg(2'(a), v);
         chk("R1 reg after reset", v, 32'h0);
      end
      rdent(1'b0, 2'd0, 4'd0, lo, hi);
      chk("R1 entry lo after reset", lo, 32'h0);
      rdent(1'b1, 2'd3, 4'd15, lo, hi);
      chk("R1 entry hi after reset", hi, 32'h0);
      chk("R1 inval after reset", 32'(inval_valid), 32'h0);

      // R5 R6 R8 table of commits
      for (int n = 0; n < 6; n++) begin
         logic [1:0] bs, way; logic [3:0] idx; logic [31:0] vh, vl;
         {bs, way, idx, vh, vl} = VEC[n];
         bank_sel = bs;
         wr(A_SEL, {26'h0, way, idx});
         wr(A_HI, vh);
         rdreg(A_CAUSE, v);
         chk("R3 cause mirrors hi", v, vh);
         rdreg(A_HI, v);
         chk("R3 hi register", v, vh);
         wr(A_LO, vl);
         chk("R8 pulse after commit", 32'(inval_valid), 32'h1);
         chk("R8 page address", inval_addr, vh & PMASK);
         rdent(bs == 2'd2, way, idx, lo, hi);
         chk(bs == 2'd1 ? "R5 bank0 lo" : "R6 bank1 lo", lo, vl);
         chk(bs == 2'd1 ? "R5 bank0 hi" : "R6 bank1 hi", hi, vh);
         @(negedge clk);
         chk("R8 pulse one cycle", 32'(inval_valid), 32'h0);
      end

      // R9 every slot keeps its value, other-bank twins stay clear
      for (int n = 0; n < 6; n++) begin
         logic [1:0] bs, way; logic [3:0] idx; logic [31:0] vh, vl;
         {bs, way, idx, vh, vl} = VEC[n];
         rdent(bs == 2'd2, way, idx, lo, hi);
         chk("R9 slot kept lo", lo, vl);
         chk("R9 slot kept hi", hi, vh);
         rdent(bs != 2'd2, way, idx, lo, hi);
         chk("R9 other bank untouched", lo, 32'h0);
      end

      // R8 same-cycle: hi write during a live pulse, then back-to-back commits
      bank_sel = 2'd1;
      wr(A_SEL, {26'h0, 2'd1, 4'd3});
      wr(A_HI, 32'hAAAA_A123);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = A_LO; wr_data = 32'h1111_0001;
      @(negedge clk);
      wr_addr = A_HI; wr_data = 32'hBBBB_B456;
      chk("R8 pulse live with hi write", 32'(inval_valid), 32'h1);
      chk("R8 pulse keeps old page", inval_addr, 32'hAAAA_A000);
      @(negedge clk);
      wr_addr = A_LO; wr_data = 32'h2222_0002;
      chk("R8 no pulse after hi write", 32'(inval_valid), 32'h0);
      @(negedge clk);
      wr_data = 32'h3333_0003;
      chk("R8 pulse for new hi", inval_addr, 32'hBBBB_A000);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8 second adjacent pulse", 32'(inval_valid), 32'h1);
      rdent(1'b0, 2'd1, 4'd3, lo, hi);
      chk("R5 later commit wins lo", lo, 32'h3333_0003);
      chk("R5 later commit hi", hi, 32'hBBBB_B456);
      @(negedge clk);
      chk("R8 pulses end", 32'(inval_valid), 32'h0);

      // R7 bank gate values 0 and 3
      for (int g = 0; g < 2; g++) begin
         bank_sel = (g == 0) ? 2'd0 : 2'd3;
         wr(A_SEL, {26'h0, 2'd2, 4'd4});
         wr(A_HI, 32'hDEAD_A000);
         wr(A_LO, 32'h5555_AAAA + 32'(g));
         chk("R7 no pulse on gated write", 32'(inval_valid), 32'h0);
         rdreg(A_LO, v);
         chk("R7 lo register still written", v, 32'h5555_AAAA + 32'(g));
         rdent(1'b0, 2'd2, 4'd4, lo, hi);
         chk("R7 bank0 untouched", lo, 32'h0);
         rdent(1'b1, 2'd2, 4'd4, lo, hi);
         chk("R7 bank1 untouched", hi, 32'h0);
      end

      // R4 cause write ignored
      wr(A_CAUSE, 32'h0BAD_F00D);
      rdreg(A_CAUSE, v);
      chk("R4 cause write ignored", v, 32'hDEAD_A000);

      // R2 selection width
      wr(A_SEL, 32'hFFFF_FFFF);
      rdreg(A_SEL, v);
      chk("R2 selection six bits", v, 32'h0000_003F);

      // R10 combinational read with no edge between
      @(negedge clk);
      rdreg(A_LO, v);
      chk("R10 read lo", v, 32'h5555_AAAB);
      rdreg(A_HI, v);
      chk("R10 read hi same phase", v, 32'hDEAD_A000);

      // R1 reset clears stored entries mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rdent(1'b0, 2'd0, 4'd0, lo, hi);
      chk("R1 entry cleared by reset", lo, 32'h0);
      rdreg(A_CAUSE, v);
      chk("R1 cause cleared by reset", v, 32'h0);
      rdreg(A_SEL, v);
      chk("R1 selection cleared by reset", v, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule